// File: doc/BRIEF.md
# LPC Memory Cycle Target Decoder

This block sits on the target side of a Low Pin Count bus and answers the host's memory read and memory write cycles. On every rising clock it samples the 4-bit LAD bus. When the framing strobe is low and LAD carries the start code, a new cycle begins. The block then takes one cycle-type nibble and eight address nibbles, and either receives a data byte or returns one. During the cycle it drives the sync and turnaround fields that belong to the target.

The decoded address is compared against a 512 KB window near the top of the 4 GB space. A 3-bit strap picks which of eight windows this instance answers. A hit in the window becomes a one-cycle read or write strobe on a simple byte port to a storage back end. One fixed register address in a companion space returns the latched levels of five general-purpose input pins. An address that hits neither is ignored and the bus is never driven.

Top module: `lpc_mem_target`

## Requirements
- R1: A cycle starts only on a clock where `frame_n` is 0 and `lad_in` is 4'h0; a clock with `frame_n` low and any other nibble starts nothing, and the later nibbles of that attempt produce no strobe and no bus drive.
- R2: The nibble after the start is the cycle type. 4'b010x is a memory read and 4'b011x is a memory write, and bit 0 is ignored. Any other type abandons the cycle with no strobe and no drive.
- R3: The eight address nibbles arrive most significant first (A[31:28] first). `mem_addr` carries A[18:0] while `mem_rd` or `mem_wr` is high.
- R4: The window is hit when A[31:22] are all ones and A[21:19] equal the bitwise inverse of `id_strap`. With strap 3'b010 the window starts at FFE80000h, and with 3'b111 it starts at FFC00000h.
- R5: A read at A[31:23] all ones, A[22]=0, A[21:19] the inverse of the strap, and A[15:0]=E100h returns `{3'b000, gpi_pins}` as the data byte, with no `mem_rd` pulse.
- R6: A read hit pulses `mem_rd` for one clock, in the first clock after the last address nibble, and samples `mem_rdata` on the next edge. After two undriven turnaround clocks the target drives SYNC 4'h0, then the low data nibble, then the high nibble, then 4'hF for one clock, and then releases the bus.
- R7: On a write, the two nibbles after the address are the data byte, low nibble first. After two undriven clocks the target drives SYNC 4'h0, then 4'hF, then releases the bus. `mem_wr` pulses with `mem_wdata` in the SYNC clock for a window hit and stays low for a register-address write.
- R8: For an address outside both spaces, `lad_oe`, `mem_rd` and `mem_wr` stay low for the whole cycle.
- R9: `frame_n` low in the middle of a cycle abandons that cycle. No strobe of the abandoned cycle follows, and a start code on that clock begins a new cycle at once.
- R10: While `rst_n` is low, `lad_oe`, `mem_rd` and `mem_wr` are 0.
- R11: `mem_rd` and `mem_wr` are never high together, and the target never drives LAD in a clock where it issues `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Sampled LAD nibble |
| lad_out | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | LAD output enable |
| id_strap | input | 3 | Window select strap |
| gpi_pins | input | 5 | General-purpose input pin levels |
| mem_addr | output | 19 | Byte address to the storage back end |
| mem_rd | output | 1 | One-clock read strobe |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_rd` |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
Some properties are checked on every clock by assertions. The two strobes never overlap, and a read strobe never coincides with a driven bus or with a driven clock that follows it. Every driven stretch opens with SYNC 4'h0, a write strobe lands in a SYNC clock, and the bus is released only after a 4'hF nibble unless an abort intervened. Other behaviour only the bench scenarios can show: the window and register decode for two strap values, the order of the address and data nibbles, the returned byte values, and the effect of an abort or a rejected start or type.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_CTYPE, ST_ADDR, ST_WD0, ST_WD1, ST_HTAR0, ST_HTAR1,
      ST_SYNC, ST_RD0, ST_RD1, ST_TTAR0, ST_TTAR1
   } lpc_state_e;

   localparam logic [3:0] NIB_START = 4'h0;
   localparam logic [3:0] NIB_READY = 4'h0;
   localparam logic [3:0] NIB_ONES  = 4'hF;
endpackage

// File: rtl/lpc_win_decode.sv
module lpc_win_decode #(
   parameter int ADDR_W    = 32,
   parameter int MEM_AW    = 19,
   parameter int ID_W      = 3,
   parameter bit GPI_EN    = 1'b1,
   parameter int GPI_OFS_W = 16,
   parameter logic [GPI_OFS_W-1:0] GPI_OFS = 16'hE100
) (
   input  logic [ADDR_W-MEM_AW-1:0] addr_hi,
   input  logic [GPI_OFS_W-1:0]     addr_lo,
   input  logic [ID_W-1:0]          id_strap,
   output logic                     arr_hit,
   output logic                     gpi_hit
);
   localparam int HI_W = ADDR_W - MEM_AW - ID_W;

   if (HI_W < 2) begin : g_bad_hi
      $error("window decode needs at least two fixed upper bits");
   end

   logic [ID_W-1:0] win_sel;
   logic            top_ones;
   assign win_sel  = addr_hi[ID_W-1:0];
   assign top_ones = &addr_hi[ADDR_W-MEM_AW-1 -: HI_W-1];

   assign arr_hit = top_ones && addr_hi[ID_W+HI_W-HI_W +: 1] == 1'b1
                    && addr_hi[ID_W] && (win_sel == ~id_strap);

   if (GPI_EN) begin : g_gpi
      assign gpi_hit = top_ones && !addr_hi[ID_W] && (win_sel == ~id_strap)
                       && (addr_lo == GPI_OFS);
   end else begin : g_no_gpi
      assign gpi_hit = 1'b0;
   end
endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
   import lpc_tgt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad_in,
   input  logic              arr_hit,
   input  logic              gpi_hit,
   output lpc_state_e        state,
   output logic              is_wr,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   localparam int NIBBLES = ADDR_W / 4;
   localparam int CNT_W   = $clog2(NIBBLES);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         is_wr <= 1'b0;
         cnt   <= '0;
         addr  <= '0;
         wdata <= '0;
      end else if (!frame_n) begin
         state <= (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: state <= ST_IDLE;
            ST_CTYPE: begin
               cnt <= '0;
               if (lad_in[3:2] == 2'b01) begin
                  is_wr <= lad_in[1];
                  state <= ST_ADDR;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_ADDR: begin
               addr <= {addr[ADDR_W-5:0], lad_in};
               cnt  <= cnt + 1'b1;
               if (cnt == CNT_W'(NIBBLES - 1))
                  state <= is_wr ? ST_WD0 : ST_HTAR0;
            end
            ST_WD0: begin
               wdata[3:0] <= lad_in;
               state      <= ST_WD1;
            end
            ST_WD1: begin
               wdata[7:4] <= lad_in;
               state      <= ST_HTAR0;
            end
            ST_HTAR0: state <= (arr_hit || gpi_hit) ? ST_HTAR1 : ST_IDLE;
            ST_HTAR1: state <= ST_SYNC;
            ST_SYNC:  state <= is_wr ? ST_TTAR0 : ST_RD0;
            ST_RD0:   state <= ST_RD1;
            ST_RD1:   state <= ST_TTAR0;
            ST_TTAR0: state <= ST_TTAR1;
            ST_TTAR1: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
   import lpc_tgt_pkg::*;
#(
   parameter int GPI_W  = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lpc_state_e        state,
   input  logic              is_wr,
   input  logic              arr_hit,
   input  logic              gpi_hit,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [GPI_W-1:0]  gpi_pins,
   output logic [3:0]        lad_out,
   output logic              lad_oe,
   output logic              mem_rd,
   output logic              mem_wr
);
   logic [GPI_W-1:0]  gpi_q;
   logic [DATA_W-1:0] rbuf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpi_q <= '0;
         rbuf  <= '0;
      end else begin
         gpi_q <= gpi_pins;
         if (state == ST_HTAR1)
            rbuf <= gpi_hit ? DATA_W'(gpi_q) : mem_rdata;
      end
   end

   always_comb begin
      lad_oe  = 1'b0;
      lad_out = NIB_ONES;
      unique case (state)
         ST_SYNC:  begin lad_oe = 1'b1; lad_out = NIB_READY;  end
         ST_RD0:   begin lad_oe = 1'b1; lad_out = rbuf[3:0];  end
         ST_RD1:   begin lad_oe = 1'b1; lad_out = rbuf[7:4];  end
         ST_TTAR0: begin lad_oe = 1'b1; lad_out = NIB_ONES;   end
         default:  ;
      endcase
   end

   assign mem_rd = (state == ST_HTAR0) && !is_wr && arr_hit;
   assign mem_wr = (state == ST_SYNC) && is_wr && arr_hit;
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
   import lpc_tgt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MEM_AW = 19,
   parameter int ID_W   = 3,
   parameter int GPI_W  = 5,
   parameter int DATA_W = 8,
   parameter bit GPI_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad_in,
   output logic [3:0]        lad_out,
   output logic              lad_oe,
   input  logic [ID_W-1:0]   id_strap,
   input  logic [GPI_W-1:0]  gpi_pins,
   output logic [MEM_AW-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam int OFS_W = 16;

   if (ADDR_W % 4 != 0) begin : g_bad_aw
      $error("address width must be a whole number of nibbles");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("data phase carries exactly two nibbles");
   end
   if (GPI_W > DATA_W) begin : g_bad_gpi
      $error("input register wider than the data byte");
   end
   if (MEM_AW < OFS_W) begin : g_bad_mem
      $error("register offset must lie inside the window offset");
   end

   lpc_state_e        state;
   logic              is_wr, arr_hit, gpi_hit;
   logic [ADDR_W-1:0] addr;

   lpc_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
      .arr_hit(arr_hit), .gpi_hit(gpi_hit), .state(state), .is_wr(is_wr),
      .addr(addr), .wdata(mem_wdata)
   );

   lpc_win_decode #(
      .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .ID_W(ID_W), .GPI_EN(GPI_EN),
      .GPI_OFS_W(OFS_W), .GPI_OFS(16'hE100)
   ) u_dec (
      .addr_hi(addr[ADDR_W-1:MEM_AW]), .addr_lo(addr[OFS_W-1:0]),
      .id_strap(id_strap), .arr_hit(arr_hit), .gpi_hit(gpi_hit)
   );

   lpc_lad_drive #(.GPI_W(GPI_W), .DATA_W(DATA_W)) u_drv (
      .clk(clk), .rst_n(rst_n), .state(state), .is_wr(is_wr),
      .arr_hit(arr_hit), .gpi_hit(gpi_hit), .mem_rdata(mem_rdata),
      .gpi_pins(gpi_pins), .lad_out(lad_out), .lad_oe(lad_oe),
      .mem_rd(mem_rd), .mem_wr(mem_wr)
   );

   assign mem_addr = addr[MEM_AW-1:0];
endmodule

// File: rtl/lpc_mem_target_chk.sv
module lpc_mem_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_n,
   input logic       lad_oe,
   input logic [3:0] lad_out,
   input logic       mem_rd,
   input logic       mem_wr
);
   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_rd_undriven_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !lad_oe);

   assert_rd_then_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && frame_n) |=> !lad_oe);

   assert_drive_opens_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lad_oe) |-> (lad_out == 4'h0));

   assert_wr_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (lad_oe && lad_out == 4'h0));

   assert_release_after_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lad_oe) && $past(frame_n)) |-> ($past(lad_out) == 4'hF));
endmodule

bind lpc_mem_target lpc_mem_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_oe(lad_oe),
   .lad_out(lad_out), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/lpc_mem_target_bench.sv
`timescale 1ns/1ps
module lpc_mem_target_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad_in = 4'hF;
   logic [3:0]  lad_out;
   logic        lad_oe;
   logic [2:0]  id_strap = 3'b010;
   logic [4:0]  gpi_pins = 5'h00;
   logic [18:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata = 8'h00;
   logic        mem_wr;
   logic [7:0]  mem_wdata;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [7:0] ram [int];
   logic [7:0] ref_mem [int];

   always #2.5 clk = ~clk;

   lpc_mem_target u_lpc_mem_target (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
      .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(id_strap),
      .gpi_pins(gpi_pins), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
   );

   // storage back end: one clock read latency
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
      if (mem_wr) ram[int'(mem_addr)] = mem_wdata;
   end

   function automatic bit win_hit(input logic [31:0] a);
      return (a[31:22] == 10'h3FF) && (a[21:19] == ~id_strap);
   endfunction

   function automatic bit reg_hit(input logic [31:0] a);
      return (a[31:23] == 9'h1FF) && !a[22] && (a[21:19] == ~id_strap)
             && (a[15:0] == 16'hE100);
   endfunction

   function automatic logic [7:0] ref_rd(input logic [31:0] a);
      return ref_mem.exists(int'(a[18:0])) ? ref_mem[int'(a[18:0])] : 8'h00;
   endfunction

   task automatic slot(input logic fr, input logic [3:0] nib,
                       input logic eoe, input logic [3:0] eout,
                       input logic erd, input logic ewr,
                       input logic [18:0] eaddr, input logic [7:0] ewd,
                       input string tag);
      @(posedge clk); #1;
      frame_n = fr;
      lad_in  = nib;
      @(negedge clk);
      total++;
      if (lad_oe !== eoe || (eoe && lad_out !== eout) || mem_rd !== erd ||
          mem_wr !== ewr || ((erd || ewr) && mem_addr !== eaddr) ||
          (ewr && mem_wdata !== ewd)) begin
         bad++;
         $display("FAIL %s: oe=%b out=%h rd=%b wr=%b addr=%h wd=%h expected oe=%b out=%h rd=%b wr=%b addr=%h wd=%h",
                  tag, lad_oe, lad_out, mem_rd, mem_wr, mem_addr, mem_wdata,
                  eoe, eout, erd, ewr, eaddr, ewd);
      end
   endtask

   task automatic xfer(input logic [3:0] st, input logic [3:0] ct,
                       input logic [31:0] a, input logic [7:0] wd,
                       input int abort_at, input string tag);
      bit valid = (st == 4'h0) && (ct[3:2] == 2'b01);
      bit wr    = ct[1];
      bit ah    = valid && win_hit(a);
      bit gh    = valid && reg_hit(a);
      bit resp  = ah || gh;
      logic [7:0] d = gh ? {3'b000, gpi_pins} : ref_rd(a);
      for (int s = 0; s <= 16; s++) begin
         logic       fr = (s != 0);
         logic [3:0] nib = 4'hF;
         logic       eoe = 1'b0, erd = 1'b0, ewr = 1'b0;
         logic [3:0] eout = 4'hF;
         if (s == abort_at) return;
         if (s == 0) nib = st;
         else if (s == 1) nib = ct;
         else if (s <= 9) nib = 4'(a >> (4 * (9 - s)));
         else if (wr && s == 10) nib = wd[3:0];
         else if (wr && s == 11) nib = wd[7:4];
         if (resp && !wr) begin
            if (s == 10) erd = ah;
            if (s == 12) begin eoe = 1; eout = 4'h0; end
            if (s == 13) begin eoe = 1; eout = d[3:0]; end
            if (s == 14) begin eoe = 1; eout = d[7:4]; end
            if (s == 15) begin eoe = 1; eout = 4'hF; end
         end
         if (resp && wr) begin
            if (s == 14) begin eoe = 1; eout = 4'h0; ewr = ah; end
            if (s == 15) begin eoe = 1; eout = 4'hF; end
         end
         slot(fr, nib, eoe, eout, erd, ewr, a[18:0], wd, tag);
      end
      if (resp && wr && ah) ref_mem[int'(a[18:0])] = wd;
      for (int k = 0; k < 2; k++)
         slot(1'b1, 4'hF, 1'b0, 4'hF, 1'b0, 1'b0, '0, '0, tag);
   endtask

   initial begin
      repeat (3) begin
         @(negedge clk);
         total++;
         if (lad_oe !== 1'b0 || mem_rd !== 1'b0 || mem_wr !== 1'b0) begin
            bad++;
            $display("FAIL R10: oe=%b rd=%b wr=%b expected 0 0 0", lad_oe, mem_rd, mem_wr);
         end
      end
      @(posedge clk); #1 rst_n = 1'b1;

      // R3 R4 R6 R7: window writes and read-back, strap 010 -> FFE80000h
      xfer(4'h0, 4'h6, 32'hFFE8_1234, 8'hA5, -1, "R7 write");
      xfer(4'h0, 4'h4, 32'hFFE8_1234, 8'h00, -1, "R6 read");
      xfer(4'h0, 4'h7, 32'hFFEF_FFFF, 8'h3C, -1, "R2 write type bit0");
      xfer(4'h0, 4'h5, 32'hFFEF_FFFF, 8'h00, -1, "R3 read top byte");
      xfer(4'h0, 4'h4, 32'hFFE8_0000, 8'h00, -1, "R4 read base");
      // R5: input register
      gpi_pins = 5'h15;
      xfer(4'h0, 4'h4, 32'hFFA8_E100, 8'h00, -1, "R5 gpi read");
      gpi_pins = 5'h0A;
      xfer(4'h0, 4'h4, 32'hFFAC_E100, 8'h00, -1, "R5 gpi read mirror");
      xfer(4'h0, 4'h6, 32'hFFA8_E100, 8'h77, -1, "R7 gpi write");
      // R8: misses
      xfer(4'h0, 4'h4, 32'hFFF0_0000, 8'h00, -1, "R8 read miss");
      xfer(4'h0, 4'h6, 32'h0008_1234, 8'h99, -1, "R8 write miss");
      xfer(4'h0, 4'h4, 32'hFFA8_E101, 8'h00, -1, "R8 near register");
      // R1, R2: rejected start and type
      xfer(4'h3, 4'h4, 32'hFFE8_1234, 8'h00, -1, "R1 bad start");
      xfer(4'h0, 4'h0, 32'hFFE8_1234, 8'h00, -1, "R2 io type");
      xfer(4'h0, 4'hC, 32'hFFE8_1234, 8'h00, -1, "R2 other type");
      // R9: aborts
      xfer(4'h0, 4'h4, 32'hFFE8_1234, 8'h00, 5, "R9 abort addr");
      xfer(4'h0, 4'h4, 32'hFFE8_1234, 8'h00, -1, "R9 restart read");
      xfer(4'h0, 4'h6, 32'hFFE8_1234, 8'h11, 11, "R9 abort data");
      xfer(4'h0, 4'h4, 32'hFFE8_1234, 8'h00, -1, "R9 data kept");
      // R4: other strap value -> FFC00000h
      id_strap = 3'b111;
      xfer(4'h0, 4'h6, 32'hFFC0_0010, 8'h5E, -1, "R4 strap write");
      xfer(4'h0, 4'h4, 32'hFFC0_0010, 8'h00, -1, "R4 strap read");
      xfer(4'h0, 4'h4, 32'hFFE8_1234, 8'h00, -1, "R4 old window miss");
      // R11 covered by strobe comparison in every slot
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule